// File: doc/BRIEF.md
# Routing-Switch Bit Editor

This block is a command processor that edits single routing-switch bits inside a cached window of configuration frames. It takes one 64-bit command at a time on a valid/ready port and returns one 64-bit reply on a second valid/ready port. A load command copies a fixed group of minor frames from the configuration target into a local window buffer. The frames are selected by a row and a major column. Query and modify commands then work on that buffer alone. A commit command writes the whole window back to the place it was loaded from, so an edit reaches the target only when it is committed.

The buffer position of a switch bit is the matrix index times a fixed matrix stride, plus an offset that depends only on the switch id. The same offset applies in every matrix. The target side is a plain synchronous port with one cycle of read latency.

Command layout, with bits counted from 63 down: `[63:48]` opcode, `[47:32]` major column, `[31:24]` selector (the row for a load, the matrix index for a query or a modify), `[23:8]` switch id, `[7:0]` argument. A reply carries the request opcode with `0x0080` ORed in at `[63:48]`.

Top module: `swcfg_cmd_proc`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_valid` is 0 and `tgt_en` is 0.
- R2: Every reply has the request opcode ORed with `0x0080` in bits [63:48]. The opcodes are load `0x0002`, commit `0x0003`, query `0x0030` and modify `0x0031`.
- R3: A load with row `r` and major `j` issues exactly 20 target reads. The reads go to minors 0 to 19 in ascending order, one per cycle, at `tgt_addr = {r[7:0], j[15:0], minor[4:0]}`. Each read word becomes buffer word `minor`. The reply is `0x0082` followed by zeros, with `0x14` in bits [7:0].
- R4: A query returns the buffered bit at position `p = matrix*32 + (id[4:0] ^ id[9:5] ^ id[14:10])` in reply bit 0. The bit is `p % 32` of buffer word `p / 32`. Bits [47:1] of the reply are zero.
- R5: A modify writes 1 to bit `p` when the argument byte is nonzero and 0 when it is zero. No other buffer bit changes and the target is not accessed. The reply bits [47:0] are zero.
- R6: A commit writes all 20 buffer words, with any edits, to minors 0 to 19 of the row and major of the most recent load. The reply has `0x14` in bits [7:0].
- R7: An unknown opcode gets a reply with bits [7:0] = `0x01` and bits [47:8] zero. It leaves the buffer unchanged and makes no target access.
- R8: A query, modify or commit issued before any load gets error code `0x02` in bits [7:0] and has no effect.
- R9: A query or modify whose position `p` is 640 or more gets error code `0x03` and leaves the buffer unchanged.
- R10: `cmd_ready` stays low from the acceptance of a command until its reply is taken. While `rsp_ready` is low, `rsp_valid` and `rsp_data` hold steady.
- R11: `tgt_we` is asserted only together with `tgt_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_data | input | 64 | Command word |
| rsp_valid | output | 1 | Reply available |
| rsp_ready | input | 1 | Reply taken by the consumer |
| rsp_data | output | 64 | Reply word |
| tgt_en | output | 1 | Target access strobe |
| tgt_we | output | 1 | Target write (with `tgt_en`) |
| tgt_addr | output | 29 | {row, major, minor} frame address |
| tgt_wdata | output | 32 | Frame word written to target |
| tgt_rdata | input | 32 | Frame word read, valid one cycle after the read strobe |

## Verification
The bench runs its query and modify patterns against a window filled from an address-hashed frame pattern, so each switch bit has a known, unrelated value. It queries one switch id in two matrices, which shows the offset is reused while the matrix base moves. It queries neighbouring ids, which shows the offset mapping tells adjacent switches apart. It toggles one bit off and on and reads it back between the two, which separates a real buffer write from a stale read. Positions 0 and 639 and matrices 20 and 255 probe the window edges. A commit compared word by word against the model shows that only the edited bits moved. A second load at another row and major shows that commit addresses follow the last load.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;

    localparam int CMD_W = 64;
    localparam int OPC_W = 16;

    localparam logic [OPC_W-1:0] OPC_LOAD   = 16'h0002;
    localparam logic [OPC_W-1:0] OPC_COMMIT = 16'h0003;
    localparam logic [OPC_W-1:0] OPC_QUERY  = 16'h0030;
    localparam logic [OPC_W-1:0] OPC_MODIFY = 16'h0031;
    localparam logic [OPC_W-1:0] REPLY_FLAG = 16'h0080;

    typedef enum logic [7:0] {
        ERR_NONE      = 8'h00,
        ERR_BAD_OP    = 8'h01,
        ERR_NO_WINDOW = 8'h02,
        ERR_RANGE     = 8'h03
    } err_e;

    // Command word fields, most significant first
    typedef struct packed {
        logic [15:0] opcode;
        logic [15:0] major;
        logic [7:0]  sel;
        logic [15:0] swid;
        logic [7:0]  arg;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DISPATCH,
        ST_XFER,
        ST_REPLY
    } state_e;

    function automatic logic [OPC_W-1:0] reply_op(input logic [OPC_W-1:0] op);
        return op | REPLY_FLAG;
    endfunction

    function automatic logic [CMD_W-1:0] err_reply(input logic [OPC_W-1:0] op, input err_e code);
        return {reply_op(op), 40'd0, code};
    endfunction

    // Per-switch-id bit offset inside one matrix; identical for all matrices
    function automatic int unsigned sw_offset(input logic [15:0] id, input int unsigned stride);
        logic [4:0] folded;
        folded = id[4:0] ^ id[9:5] ^ id[14:10];
        return int'(folded) % stride;
    endfunction

endpackage

// File: rtl/swcfg_bitpos.sv
module swcfg_bitpos #(
    parameter int FRAME_W    = 32,
    parameter int N_MINORS   = 20,
    parameter int MTX_STRIDE = 32,
    localparam int IDX_W = $clog2(N_MINORS),
    localparam int BIT_W = $clog2(FRAME_W)
) (
    input  logic [7:0]       matrix,
    input  logic [15:0]      swid,
    output logic [IDX_W-1:0] word_idx,
    output logic [BIT_W-1:0] bit_idx,
    output logic             in_range
);
    import swcfg_pkg::*;

    localparam int unsigned TOTAL_BITS = N_MINORS * FRAME_W;

    logic [31:0] pos;

    always_comb begin
        pos      = 32'(matrix) * 32'(MTX_STRIDE) + 32'(sw_offset(swid, MTX_STRIDE));
        in_range = (pos < 32'(TOTAL_BITS));
        word_idx = IDX_W'(pos / 32'(FRAME_W));
        bit_idx  = BIT_W'(pos % 32'(FRAME_W));
    end

endmodule

// File: rtl/swcfg_frame_buf.sv
module swcfg_frame_buf #(
    parameter int FRAME_W  = 32,
    parameter int N_MINORS = 20,
    localparam int IDX_W = $clog2(N_MINORS)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [FRAME_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr_a,
    output logic [FRAME_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]   raddr_b,
    output logic [FRAME_W-1:0] rdata_b
);
    logic [FRAME_W-1:0] mem [N_MINORS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/swcfg_xfer.sv
module swcfg_xfer #(
    parameter int FRAME_W  = 32,
    parameter int N_MINORS = 20,
    parameter int REG_W    = 24,
    localparam int IDX_W = $clog2(N_MINORS),
    localparam int AW    = REG_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               to_target,
    input  logic [REG_W-1:0]   region,
    output logic               done,
    output logic               tgt_en,
    output logic               tgt_we,
    output logic [AW-1:0]      tgt_addr,
    output logic [FRAME_W-1:0] tgt_wdata,
    input  logic [FRAME_W-1:0] tgt_rdata,
    output logic               buf_we,
    output logic [IDX_W-1:0]   buf_waddr,
    output logic [FRAME_W-1:0] buf_wdata,
    output logic [IDX_W-1:0]   buf_raddr,
    input  logic [FRAME_W-1:0] buf_rdata
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_MINORS - 1);

    logic             active;
    logic             store_q;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] region_q;
    logic             cap_pend;
    logic [IDX_W-1:0] cap_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            store_q  <= 1'b0;
            idx      <= '0;
            region_q <= '0;
            cap_pend <= 1'b0;
            cap_idx  <= '0;
            done     <= 1'b0;
        end else begin
            done     <= 1'b0;
            cap_pend <= 1'b0;
            if (start) begin
                active   <= 1'b1;
                store_q  <= to_target;
                idx      <= '0;
                region_q <= region;
            end else if (active) begin
                idx <= idx + 1'b1;
                if (!store_q) begin
                    cap_pend <= 1'b1;
                    cap_idx  <= idx;
                end
                if (idx == LAST) begin
                    active <= 1'b0;
                    if (store_q) begin
                        done <= 1'b1;
                    end
                end
            end
            // Final read word lands in the buffer on this edge
            if (cap_pend && cap_idx == LAST) begin
                done <= 1'b1;
            end
        end
    end

    assign tgt_en    = active;
    assign tgt_we    = active & store_q;
    assign tgt_addr  = {region_q, idx};
    assign buf_raddr = idx;
    assign tgt_wdata = buf_rdata;
    assign buf_we    = cap_pend;
    assign buf_waddr = cap_idx;
    assign buf_wdata = tgt_rdata;

endmodule

// File: rtl/swcfg_cmd_proc.sv
module swcfg_cmd_proc #(
    parameter int FRAME_W    = 32,
    parameter int N_MINORS   = 20,
    parameter int MTX_STRIDE = 32,
    localparam int IDX_W  = $clog2(N_MINORS),
    localparam int BIT_W  = $clog2(FRAME_W),
    localparam int REG_W  = 24,
    localparam int TGT_AW = REG_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [63:0]        cmd_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [63:0]        rsp_data,
    output logic               tgt_en,
    output logic               tgt_we,
    output logic [TGT_AW-1:0]  tgt_addr,
    output logic [FRAME_W-1:0] tgt_wdata,
    input  logic [FRAME_W-1:0] tgt_rdata
);
    import swcfg_pkg::*;

    state_e           state;
    cmd_t             cmd_q;
    logic             loaded;
    logic [REG_W-1:0] win_region;
    logic [63:0]      rsp_q;

    logic [IDX_W-1:0]   word_idx;
    logic [BIT_W-1:0]   bit_idx;
    logic               in_range;
    logic [FRAME_W-1:0] word_now;
    logic [FRAME_W-1:0] word_patched;
    logic               bit_now;

    logic               xfer_start;
    logic               xfer_to_tgt;
    logic [REG_W-1:0]   xfer_region;
    logic               xfer_done;
    logic               eng_we;
    logic [IDX_W-1:0]   eng_waddr;
    logic [FRAME_W-1:0] eng_wdata;
    logic [IDX_W-1:0]   eng_raddr;
    logic [FRAME_W-1:0] eng_rdata;

    logic               cmd_we;
    logic               buf_we;
    logic [IDX_W-1:0]   buf_waddr;
    logic [FRAME_W-1:0] buf_wdata;

    logic               in_dispatch;
    logic               op_load;
    logic               op_commit;
    logic               op_modify;

    swcfg_bitpos #(
        .FRAME_W   (FRAME_W),
        .N_MINORS  (N_MINORS),
        .MTX_STRIDE(MTX_STRIDE)
    ) u_pos (
        .matrix  (cmd_q.sel),
        .swid    (cmd_q.swid),
        .word_idx(word_idx),
        .bit_idx (bit_idx),
        .in_range(in_range)
    );

    swcfg_frame_buf #(
        .FRAME_W (FRAME_W),
        .N_MINORS(N_MINORS)
    ) u_buf (
        .clk    (clk),
        .we     (buf_we),
        .waddr  (buf_waddr),
        .wdata  (buf_wdata),
        .raddr_a(word_idx),
        .rdata_a(word_now),
        .raddr_b(eng_raddr),
        .rdata_b(eng_rdata)
    );

    swcfg_xfer #(
        .FRAME_W (FRAME_W),
        .N_MINORS(N_MINORS),
        .REG_W   (REG_W)
    ) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .start    (xfer_start),
        .to_target(xfer_to_tgt),
        .region   (xfer_region),
        .done     (xfer_done),
        .tgt_en   (tgt_en),
        .tgt_we   (tgt_we),
        .tgt_addr (tgt_addr),
        .tgt_wdata(tgt_wdata),
        .tgt_rdata(tgt_rdata),
        .buf_we   (eng_we),
        .buf_waddr(eng_waddr),
        .buf_wdata(eng_wdata),
        .buf_raddr(eng_raddr),
        .buf_rdata(eng_rdata)
    );

    // Opcode decode of the held command
    always_comb begin
        in_dispatch = (state == ST_DISPATCH);
        op_load     = (cmd_q.opcode == OPC_LOAD);
        op_commit   = (cmd_q.opcode == OPC_COMMIT);
        op_modify   = (cmd_q.opcode == OPC_MODIFY);
    end

    // Bit extraction and in-place patch of the addressed word
    always_comb begin
        bit_now               = word_now[bit_idx];
        word_patched          = word_now;
        word_patched[bit_idx] = (cmd_q.arg != 8'd0);
    end

    // Transfer launch and buffer write arbitration
    always_comb begin
        xfer_start  = in_dispatch && (op_load || (op_commit && loaded));
        xfer_to_tgt = op_commit;
        xfer_region = op_load ? {cmd_q.sel, cmd_q.major} : win_region;
        cmd_we      = in_dispatch && op_modify && loaded && in_range;
        if (eng_we) begin
            buf_we    = 1'b1;
            buf_waddr = eng_waddr;
            buf_wdata = eng_wdata;
        end else begin
            buf_we    = cmd_we;
            buf_waddr = word_idx;
            buf_wdata = word_patched;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cmd_q      <= '0;
            loaded     <= 1'b0;
            win_region <= '0;
            rsp_q      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cmd_q <= cmd_t'(cmd_data);
                        state <= ST_DISPATCH;
                    end
                end
                ST_DISPATCH: begin
                    state <= ST_REPLY;
                    unique case (cmd_q.opcode)
                        OPC_QUERY: begin
                            if (!loaded)
                                rsp_q <= err_reply(cmd_q.opcode, ERR_NO_WINDOW);
                            else if (!in_range)
                                rsp_q <= err_reply(cmd_q.opcode, ERR_RANGE);
                            else
                                rsp_q <= {reply_op(cmd_q.opcode), 47'd0, bit_now};
                        end
                        OPC_MODIFY: begin
                            if (!loaded)
                                rsp_q <= err_reply(cmd_q.opcode, ERR_NO_WINDOW);
                            else if (!in_range)
                                rsp_q <= err_reply(cmd_q.opcode, ERR_RANGE);
                            else
                                rsp_q <= {reply_op(cmd_q.opcode), 48'd0};
                        end
                        OPC_LOAD: begin
                            state <= ST_XFER;
                        end
                        OPC_COMMIT: begin
                            if (!loaded)
                                rsp_q <= err_reply(cmd_q.opcode, ERR_NO_WINDOW);
                            else
                                state <= ST_XFER;
                        end
                        default: begin
                            rsp_q <= err_reply(cmd_q.opcode, ERR_BAD_OP);
                        end
                    endcase
                end
                ST_XFER: begin
                    if (xfer_done) begin
                        if (op_load) begin
                            loaded     <= 1'b1;
                            win_region <= {cmd_q.sel, cmd_q.major};
                        end
                        rsp_q <= {reply_op(cmd_q.opcode), 40'd0, 8'(N_MINORS)};
                        state <= ST_REPLY;
                    end
                end
                ST_REPLY: begin
                    if (rsp_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_REPLY);
    assign rsp_data  = rsp_q;

endmodule

// File: rtl/swcfg_cmd_proc_chk.sv
module swcfg_cmd_proc_chk #(
    parameter int FRAME_W = 32,
    parameter int IDX_W   = 5,
    parameter int TGT_AW  = 29
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [63:0]        rsp_data,
    input logic               tgt_en,
    input logic               tgt_we,
    input logic [TGT_AW-1:0]  tgt_addr
);
    logic             rd_now;
    logic [IDX_W-1:0] minor_now;

    assign rd_now    = tgt_en && !tgt_we;
    assign minor_now = tgt_addr[IDX_W-1:0];

    AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (rst)
        tgt_we |-> tgt_en); // R11

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10

    AST_NO_ACCEPT_DURING_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_ready); // R10

    AST_REPLY_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_data[55]); // R2

    AST_QUERY_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_data[63:48] == 16'h00B0) |-> (rsp_data[47:8] == 40'd0)); // R4

    AST_MODIFY_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_data[63:48] == 16'h00B1) |-> (rsp_data[47:8] == 40'd0)); // R5

    AST_TGT_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready || rsp_valid) |-> !tgt_en); // R7

    AST_LOAD_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (rd_now && $past(rd_now)) |-> (minor_now == IDX_W'($past(minor_now) + 1'b1))); // R3

endmodule

bind swcfg_cmd_proc swcfg_cmd_proc_chk #(
    .FRAME_W(FRAME_W),
    .IDX_W  (IDX_W),
    .TGT_AW (TGT_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data),
    .tgt_en   (tgt_en),
    .tgt_we   (tgt_we),
    .tgt_addr (tgt_addr)
);

// File: tb/swcfg_cmd_proc_tb.sv
module swcfg_cmd_proc_tb;

    localparam int NM = 20;
    localparam int WATCHDOG = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_data;
    logic        tgt_en;
    logic        tgt_we;
    logic [28:0] tgt_addr;
    logic [31:0] tgt_wdata;
    logic [31:0] tgt_rdata = '0;

    always #4 clk = ~clk;

    swcfg_cmd_proc u_dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .tgt_en(tgt_en), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Target model
    int          rd_count = 0;
    int          wr_count = 0;
    int          rd_bad   = 0;
    int          wr_bad   = 0;
    logic [23:0] exp_region = '0;
    logic [31:0] wlog [NM];

    function automatic logic [31:0] pat(input logic [28:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    always @(posedge clk) begin
        if (tgt_en && !tgt_we) begin
            tgt_rdata <= pat(tgt_addr);
            if (tgt_addr[28:5] != exp_region || int'(tgt_addr[4:0]) != (rd_count % NM))
                rd_bad = rd_bad + 1;
            rd_count = rd_count + 1;
        end
        if (tgt_en && tgt_we) begin
            if (tgt_addr[28:5] != exp_region || int'(tgt_addr[4:0]) != (wr_count % NM))
                wr_bad = wr_bad + 1;
            else
                wlog[tgt_addr[4:0]] = tgt_wdata;
            wr_count = wr_count + 1;
        end
    end

    // Reference window model
    logic [31:0] mbuf [NM];
    logic        mloaded = 1'b0;

    function automatic int offs(input logic [15:0] id);
        return int'(id & 16'd31) ^ int'((id >> 5) & 16'd31) ^ int'((id >> 10) & 16'd31);
    endfunction

    function automatic logic [63:0] model(input logic [63:0] c);
        logic [15:0] op;
        int          pos;
        op = c[63:48];
        if (op != 16'h0030 && op != 16'h0031) return {op | 16'h0080, 40'd0, 8'h01};
        if (!mloaded) return {op | 16'h0080, 40'd0, 8'h02};
        pos = int'(c[31:24]) * 32 + offs(c[23:8]);
        if (pos >= 640) return {op | 16'h0080, 40'd0, 8'h03};
        if (op == 16'h0030) return {16'h00B0, 47'd0, mbuf[pos / 32][pos % 32]};
        mbuf[pos / 32][pos % 32] = (c[7:0] != 8'd0);
        return {16'h00B1, 48'd0};
    endfunction

    localparam int NV = 16;
    localparam logic [63:0] VEC [NV] = '{
        64'h0030_000f_0d_0878_00,
        64'h0031_000f_0d_0878_00,
        64'h0030_000f_0d_0878_00,
        64'h0031_000f_0d_0878_01,
        64'h0030_000f_0d_0878_00,
        64'h0030_000f_0d_0879_00,
        64'h0030_000f_07_0878_00,
        64'h0031_000f_00_0000_ff,
        64'h0030_000f_00_0000_00,
        64'h0031_000f_13_7fff_00,
        64'h0030_000f_13_7fff_00,
        64'h0030_000f_14_0000_00,
        64'h0031_000f_ff_0001_01,
        64'h0044_0000_0000_0000,
        64'h0031_000f_05_1234_07,
        64'h0030_000f_05_1234_00
    };

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string req);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic send(input logic [63:0] c);
        @(negedge clk);
        cmd_data  = c;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic take(output logic [63:0] r);
        while (!rsp_valid) @(negedge clk);
        r = rsp_data;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic xact(input logic [63:0] c, output logic [63:0] r);
        send(c);
        take(r);
    endtask

    task automatic do_load(input logic [7:0] row, input logic [15:0] maj);
        logic [63:0] r;
        int          rd0;
        int          bad0;
        exp_region = {row, maj};
        rd0  = rd_count;
        bad0 = rd_bad;
        xact({16'h0002, maj, row, 24'h001500}, r);
        check(r, {16'h0082, 40'd0, 8'h14}, "R3 load reply");
        check(64'(rd_count - rd0), 64'(NM), "R3 read count");
        check(64'(rd_bad - bad0), 64'd0, "R3 read address order");
        for (int i = 0; i < NM; i++) mbuf[i] = pat({row, maj, 5'(i)});
        mloaded = 1'b1;
    endtask

    task automatic do_commit(input string tag);
        logic [63:0] r;
        int          wr0;
        int          bad0;
        wr0  = wr_count;
        bad0 = wr_bad;
        xact(64'h0003_0000_0015_7800, r);
        check(r, {16'h0083, 40'd0, 8'h14}, "R6 commit reply");
        check(64'(wr_count - wr0), 64'(NM), "R6 write count");
        check(64'(wr_bad - bad0), 64'd0, "R6 write address");
        for (int i = 0; i < NM; i++) check(64'(wlog[i]), 64'(mbuf[i]), tag);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL R10 watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        logic [63:0] held;
        int          acc0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({63'd0, cmd_ready}, 64'd1, "R1 cmd_ready");
        check({63'd0, rsp_valid}, 64'd0, "R1 rsp_valid");
        check({63'd0, tgt_en}, 64'd0, "R1 tgt_en");

        // R8 commands before any load
        acc0 = rd_count + wr_count;
        xact(64'h0030_000f_0d_0878_00, r);
        check(r, 64'h00B0_0000_0000_0002, "R8 query before load");
        xact(64'h0031_000f_0d_0878_01, r);
        check(r, 64'h00B1_0000_0000_0002, "R8 modify before load");
        xact(64'h0003_0000_0015_7800, r);
        check(r, 64'h0083_0000_0000_0002, "R8 commit before load");
        check(64'(rd_count + wr_count - acc0), 64'd0, "R8 no target access");

        // R7 unknown opcode
        xact(64'h0044_1234_5678_9abc, r);
        check(r, 64'h00C4_0000_0000_0001, "R7 unknown opcode");

        // R3 load window
        do_load(8'h00, 16'h000f);

        // R4 R5 R9 R2 vector table
        acc0 = rd_count + wr_count;
        for (int v = 0; v < NV; v++) begin
            logic [63:0] e;
            e = model(VEC[v]);
            xact(VEC[v], r);
            check(r, e, "R4/R5/R9/R2 vector");
        end
        check(64'(rd_count + wr_count - acc0), 64'd0, "R5 modify leaves target untouched");

        // R6 commit reflects edits only
        do_commit("R6 committed word");

        // R10 reply held while consumer stalls
        send(64'h0030_000f_0d_0878_00);
        while (!rsp_valid) @(negedge clk);
        held = rsp_data;
        repeat (5) @(negedge clk);
        check({62'd0, rsp_valid, cmd_ready}, 64'd2, "R10 hold handshake");
        check(rsp_data, held, "R10 reply stable");
        take(r);
        check(r, model(64'h0030_000f_0d_0878_00), "R10 reply value");
        @(negedge clk);
        check({63'd0, cmd_ready}, 64'd1, "R10 ready after handoff");

        // R3 R6 second window at another address
        do_load(8'h02, 16'h0007);
        xact(64'h0031_0007_03_0005_01, r);
        check(r, model(64'h0031_0007_03_0005_01), "R5 modify in second window");
        xact(64'h0030_0007_03_0005_00, r);
        check(r, {16'h00B0, 47'd0, 1'b1}, "R4 readback in second window");
        do_commit("R6 second window word");

        // R9 range error leaves buffer untouched
        xact(64'h0031_0007_14_0000_01, r);
        check(r, 64'h00B1_0000_0000_0003, "R9 modify out of range");
        do_commit("R9 buffer unchanged after range error");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule